// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block serves a bus-master storage DMA engine. Given the base of a descriptor table in memory, a byte count and a transfer direction, it fetches eight-byte descriptors one at a time through a simple memory read port. It turns the buffer regions they describe into a sequence of (address, length, direction) bursts for a downstream data mover. It stops when the requested byte count has been covered, or when the table runs out first, and then reports which of the two happened.

Each descriptor holds a 32-bit buffer address in its low word and a size/flags word in its high word. The walker clears bit 0 of the 16-bit size field, treats a zero size as 64 KiB, and treats bit 31 of the size word as an end-of-table marker. A fail-safe limits the walk to a fixed span of table bytes, which protects against a table that never sets the end marker. A burst never crosses a descriptor boundary and never exceeds the bytes still owed.

Three interfaces use valid/ready: the fetch request (`fetch_*`), the fetch response (`resp_*`) and the burst output (`burst_*`). A transfer takes place on a clock edge where valid and ready are both high. Once the walker raises `fetch_valid` or `burst_valid`, it holds that valid and the payload steady until the handshake completes. The walker raises `resp_ready` only while one fetch is outstanding. The far side may stall any of these for as long as it likes.

Top module: `sgw_walker`

## Requirements
- R1: From the 64-bit fetch response, the buffer address is bits 31:0. The byte length is bits 47:32 with bit 32 forced to zero, so every decoded length is even. Bits 62:48 are ignored.
- R2: A decoded 16-bit length of zero stands for 65536 bytes.
- R3: When bit 63 (bit 31 of the size word) is set, that descriptor is the final one. After it is used up, no further fetch is issued, and any bytes still owed end the run with the exhausted code.
- R4: Fetch addresses within a run are the table base, then base+8, base+16 and so on. At most one fetch is outstanding, and `resp_ready` is high only while a fetch is outstanding.
- R5: When the current descriptor is used up and the table pointer has already advanced FAILSAFE_BYTES or more past the base, the run ends with the exhausted code and no further fetch, even without an end marker.
- R6: Each burst length is the smaller of the bytes still owed and the bytes left in the current descriptor. The burst address is the descriptor address advanced by all earlier bursts taken from that descriptor, and the sum of burst lengths never exceeds the byte count.
- R7: An accepted start reloads the table pointer from `table_base` and discards any partly used descriptor, so every run fetches from the base first.
- R8: At the end of a run, `done` pulses for exactly one cycle and `busy` falls. `done_status` becomes 2'b01 when the byte count was covered or 2'b10 when the table ended first. `err` is high exactly for 2'b10. Both hold until the next accepted start, which clears them to 2'b00 and 0.
- R9: While `fetch_valid` or `burst_valid` is high and unanswered, that valid and its payload do not change.
- R10: A start pulse while `busy` is high is ignored.
- R11: A byte count of zero completes with code 2'b01 without any fetch or burst.
- R12: Every burst carries the direction bit sampled at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| table_base | input | TBL_AW | Byte address of the first descriptor |
| dir_to_mem | input | 1 | Direction copied onto every burst (1 = write to memory) |
| byte_count | input | CNT_W | Bytes to cover in this run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| done_status | output | 2 | 01 covered, 10 table exhausted, 00 none or running |
| err | output | 1 | Table ended before the count was covered |
| fetch_valid | output | 1 | Descriptor fetch request valid |
| fetch_ready | input | 1 | Memory accepts the fetch request |
| fetch_addr | output | TBL_AW | Address of the descriptor to read |
| resp_valid | input | 1 | Descriptor data valid |
| resp_ready | output | 1 | Walker accepts descriptor data |
| resp_data | input | 64 | Descriptor, little-endian address word then size word |
| burst_valid | output | 1 | Burst request valid |
| burst_ready | input | 1 | Data mover accepts the burst |
| burst_addr | output | 32 | Burst start address |
| burst_len | output | 17 | Burst length in bytes (1 to 65536) |
| burst_dir | output | 1 | Burst direction |

## Verification
The bound checker enforces the handshake rules on every cycle. It checks that payloads hold while stalled, that only one fetch is outstanding, that fetch addresses step by eight from the base, and that the direction matches the one latched at start. It also tracks a running byte budget, so that no burst overdraws it and every covered run ends with the budget at zero, and it checks that done is a single-cycle pulse with a consistent code. Other behaviour can only be shown by the bench's scenarios, which compare every fetch and burst against a list computed from the table. These cover the length decode with bit 0 masked and zero meaning 64 KiB, the end-marker and fail-safe stops, the refetch from the base on each new start, and a start pulse ignored while busy.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int DESC_BYTES = 8;
  localparam int DESC_W     = DESC_BYTES * 8;
  localparam int BUF_AW     = 32;
  localparam int SIZE_LO    = 32;
  localparam int LAST_BIT   = 63;
  localparam int SEG_LEN_W  = 17;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_EVAL  = 3'd1,
    ST_FREQ  = 3'd2,
    ST_FWAIT = 3'd3,
    ST_BURST = 3'd4
  } walk_st_e;

  typedef enum logic [1:0] {
    RES_NONE   = 2'b00,
    RES_FILLED = 2'b01,
    RES_SHORT  = 2'b10
  } walk_res_e;

  typedef struct packed {
    logic [BUF_AW-1:0]    addr;
    logic [SEG_LEN_W-1:0] len;
    logic                 last;
  } seg_t;
endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode
  import sgw_pkg::*;
(
  input  logic [DESC_W-1:0] raw,
  output seg_t              seg
);
  logic [15:0] enc_len;

  always_comb begin
    // bit 0 of the size field never counts
    enc_len  = {raw[SIZE_LO+15:SIZE_LO+1], 1'b0};
    seg.addr = raw[BUF_AW-1:0];
    seg.len  = (enc_len == 16'd0) ? {1'b1, 16'h0000} : {1'b0, enc_len};
    seg.last = raw[LAST_BIT];
  end
endmodule

// File: rtl/sgw_table_ptr.sv
module sgw_table_ptr #(
  parameter int AW    = 32,
  parameter int LIMIT = 4096,
  parameter int STEP  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base_in,
  output logic [AW-1:0] ptr,
  output logic          limit_hit
);
  logic [AW-1:0] base_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] offs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else if (load) begin
      base_q <= base_in;
      ptr_q  <= base_in;
    end else if (step) begin
      ptr_q <= ptr_q + AW'(STEP);
    end
  end

  assign offs      = ptr_q - base_q;
  assign limit_hit = (offs >= AW'(LIMIT));
  assign ptr       = ptr_q;
endmodule

// File: rtl/sgw_seg_track.sv
module sgw_seg_track
  import sgw_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 load,
  input  logic                 consume,
  input  seg_t                 seg_in,
  input  logic [CNT_W-1:0]     count_in,
  output seg_t                 seg,
  output logic [SEG_LEN_W-1:0] take,
  output logic                 seg_empty,
  output logic                 rem_zero
);
  localparam int CMP_W = (CNT_W > SEG_LEN_W) ? CNT_W : SEG_LEN_W;

  seg_t             seg_q;
  logic [CNT_W-1:0] rem_q;
  logic [CMP_W-1:0] rem_w;
  logic [CMP_W-1:0] len_w;
  logic [CMP_W-1:0] take_w;

  always_comb begin
    rem_w  = CMP_W'(rem_q);
    len_w  = CMP_W'(seg_q.len);
    take_w = (rem_w < len_w) ? rem_w : len_w;
    take   = SEG_LEN_W'(take_w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q <= '0;
      rem_q <= '0;
    end else if (clear) begin
      seg_q <= '0;
      rem_q <= count_in;
    end else if (load) begin
      seg_q <= seg_in;
    end else if (consume) begin
      seg_q.addr <= seg_q.addr + BUF_AW'(take);
      seg_q.len  <= seg_q.len - take;
      rem_q      <= rem_q - CNT_W'(take);
    end
  end

  assign seg       = seg_q;
  assign seg_empty = (seg_q.len == '0);
  assign rem_zero  = (rem_q == '0);
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
  import sgw_pkg::*;
#(
  parameter int CNT_W          = 24,
  parameter int TBL_AW         = 32,
  parameter int FAILSAFE_BYTES = 4096
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [TBL_AW-1:0]    table_base,
  input  logic                 dir_to_mem,
  input  logic [CNT_W-1:0]     byte_count,
  output logic                 busy,
  output logic                 done,
  output logic [1:0]           done_status,
  output logic                 err,
  output logic                 fetch_valid,
  input  logic                 fetch_ready,
  output logic [TBL_AW-1:0]    fetch_addr,
  input  logic                 resp_valid,
  output logic                 resp_ready,
  input  logic [DESC_W-1:0]    resp_data,
  output logic                 burst_valid,
  input  logic                 burst_ready,
  output logic [BUF_AW-1:0]    burst_addr,
  output logic [SEG_LEN_W-1:0] burst_len,
  output logic                 burst_dir
);
  walk_st_e  st_q, st_d;
  walk_res_e res_q, fin_code;
  logic      done_q, err_q, dir_q;
  logic      accept, finish;
  logic      fetch_hs, resp_hs, burst_hs;
  logic      limit_hit, seg_empty, rem_zero;
  seg_t      dec_seg, cur_seg;
  logic [SEG_LEN_W-1:0] take;

  assign accept   = (st_q == ST_IDLE) && start;
  assign fetch_hs = fetch_valid && fetch_ready;
  assign resp_hs  = resp_valid && resp_ready;
  assign burst_hs = burst_valid && burst_ready;

  sgw_desc_decode u_dec (
    .raw (resp_data),
    .seg (dec_seg)
  );

  sgw_table_ptr #(
    .AW    (TBL_AW),
    .LIMIT (FAILSAFE_BYTES),
    .STEP  (DESC_BYTES)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .step      (fetch_hs),
    .base_in   (table_base),
    .ptr       (fetch_addr),
    .limit_hit (limit_hit)
  );

  sgw_seg_track #(
    .CNT_W (CNT_W)
  ) u_seg (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .load      (resp_hs),
    .consume   (burst_hs),
    .seg_in    (dec_seg),
    .count_in  (byte_count),
    .seg       (cur_seg),
    .take      (take),
    .seg_empty (seg_empty),
    .rem_zero  (rem_zero)
  );

  always_comb begin
    st_d     = st_q;
    finish   = 1'b0;
    fin_code = RES_NONE;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_EVAL;
      ST_EVAL: begin
        if (rem_zero) begin
          finish   = 1'b1;
          fin_code = RES_FILLED;
          st_d     = ST_IDLE;
        end else if (seg_empty) begin
          if (cur_seg.last || limit_hit) begin
            finish   = 1'b1;
            fin_code = RES_SHORT;
            st_d     = ST_IDLE;
          end else begin
            st_d = ST_FREQ;
          end
        end else begin
          st_d = ST_BURST;
        end
      end
      ST_FREQ:  if (fetch_ready) st_d = ST_FWAIT;
      ST_FWAIT: if (resp_valid)  st_d = ST_EVAL;
      ST_BURST: if (burst_ready) st_d = ST_EVAL;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      res_q  <= RES_NONE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
      if (accept) begin
        res_q <= RES_NONE;
        err_q <= 1'b0;
        dir_q <= dir_to_mem;
      end else if (finish) begin
        res_q <= fin_code;
        err_q <= (fin_code == RES_SHORT);
      end
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign done_status = res_q;
  assign err         = err_q;
  assign fetch_valid = (st_q == ST_FREQ);
  assign resp_ready  = (st_q == ST_FWAIT);
  assign burst_valid = (st_q == ST_BURST);
  assign burst_addr  = cur_seg.addr;
  assign burst_len   = take;
  assign burst_dir   = dir_q;
endmodule

// File: rtl/sgw_walker_chk.sv
module sgw_walker_chk
  import sgw_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int TBL_AW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic [TBL_AW-1:0]    table_base,
  input logic                 dir_to_mem,
  input logic [CNT_W-1:0]     byte_count,
  input logic                 busy,
  input logic                 done,
  input logic [1:0]           done_status,
  input logic                 err,
  input logic                 fetch_valid,
  input logic                 fetch_ready,
  input logic [TBL_AW-1:0]    fetch_addr,
  input logic                 resp_valid,
  input logic                 resp_ready,
  input logic [DESC_W-1:0]    resp_data,
  input logic                 burst_valid,
  input logic                 burst_ready,
  input logic [BUF_AW-1:0]    burst_addr,
  input logic [SEG_LEN_W-1:0] burst_len,
  input logic                 burst_dir
);
  logic              pend, fetched, dir_c;
  logic [TBL_AW-1:0] base_c, last_fa;
  logic [CNT_W-1:0]  budget;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      fetched <= 1'b0;
      dir_c   <= 1'b0;
      base_c  <= '0;
      last_fa <= '0;
      budget  <= '0;
    end else begin
      if (start && !busy) begin
        fetched <= 1'b0;
        dir_c   <= dir_to_mem;
        base_c  <= table_base;
        budget  <= byte_count;
      end
      if (fetch_valid && fetch_ready) begin
        pend    <= 1'b1;
        fetched <= 1'b1;
        last_fa <= fetch_addr;
      end
      if (resp_valid && resp_ready) pend <= 1'b0;
      if (burst_valid && burst_ready) budget <= budget - CNT_W'(burst_len);
    end
  end

  assert_fetch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_addr));

  assert_burst_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && !burst_ready |=> burst_valid && $stable(burst_addr)
                                    && $stable(burst_len) && $stable(burst_dir));

  assert_one_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> !pend);

  assert_resp_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ready |-> pend);

  assert_fetch_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> fetch_addr == (fetched ? last_fa + TBL_AW'(DESC_BYTES) : base_c));

  assert_burst_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> burst_len != '0 && burst_len <= {1'b1, 16'h0000}
                    && CNT_W'(burst_len) <= budget);

  assert_dir_R12: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> burst_dir == dir_c);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && ((done_status == 2'b01 && !err && budget == '0)
                       || (done_status == 2'b10 && err)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fetch_valid && !burst_valid && !resp_ready);
endmodule

bind sgw_walker sgw_walker_chk #(.CNT_W(CNT_W), .TBL_AW(TBL_AW)) u_chk (.*);

// File: tb/tb_sgw_walker.sv
`timescale 1ns/1ps
module tb_sgw_walker;
  localparam int CNT_W = 24;
  localparam int AW    = 32;
  localparam int FS    = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             start = 1'b0;
  logic [AW-1:0]    table_base = '0;
  logic             dir_to_mem = 1'b0;
  logic [CNT_W-1:0] byte_count = '0;
  logic             busy, done, err;
  logic [1:0]       done_status;
  logic             fetch_valid, fetch_ready;
  logic [AW-1:0]    fetch_addr;
  logic             resp_valid, resp_ready;
  logic [63:0]      resp_data;
  logic             burst_valid, burst_ready;
  logic [31:0]      burst_addr;
  logic [16:0]      burst_len;
  logic             burst_dir;

  sgw_walker #(.CNT_W(CNT_W), .TBL_AW(AW), .FAILSAFE_BYTES(FS)) dut (.*);

  logic [63:0]   tbl [16];
  logic [AW-1:0] mem_base;
  int            lat;
  logic [AW-1:0] got_f  [32];
  logic [31:0]   got_ba [32];
  logic [16:0]   got_bl [32];
  logic          got_bd [32];
  int            nf, nb, ndone;
  logic [AW-1:0] exp_f  [32];
  logic [31:0]   exp_ba [32];
  longint        exp_bl [32];
  int            nef, neb;
  logic [1:0]    exp_status;
  int            checks = 0;
  int            errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // memory and data-mover model: all driving at the falling edge
  initial begin
    logic          f_hs, r_hs, b_hs, pend;
    logic [AW-1:0] f_a, p_a, diff;
    logic [31:0]   b_a;
    logic [16:0]   b_l;
    logic          b_d;
    int            wait_c, cyc;
    f_hs = 0; r_hs = 0; b_hs = 0; pend = 0; f_a = '0; p_a = '0; diff = '0;
    b_a = '0; b_l = '0; b_d = 0; wait_c = 0; cyc = 0;
    fetch_ready = 0; resp_valid = 0; resp_data = '0; burst_ready = 0;
    nf = 0; nb = 0; ndone = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (f_hs) begin
        if (nf < 32) got_f[nf] = f_a;
        nf++;
        pend = 1; p_a = f_a; wait_c = lat;
      end
      if (r_hs) resp_valid = 0;
      if (b_hs) begin
        if (nb < 32) begin got_ba[nb] = b_a; got_bl[nb] = b_l; got_bd[nb] = b_d; end
        nb++;
      end
      if (pend && !resp_valid) begin
        if (wait_c == 0) begin
          diff = p_a - mem_base;
          resp_data  = (diff < 128) ? tbl[diff[6:3]] : 64'h0;
          resp_valid = 1; pend = 0;
        end else wait_c--;
      end
      if (done) ndone++;
      fetch_ready = (cyc % 3) != 0;
      burst_ready = (cyc % 4) != 1;
      f_hs = fetch_valid && fetch_ready; f_a = fetch_addr;
      r_hs = resp_valid && resp_ready;
      b_hs = burst_valid && burst_ready;
      b_a = burst_addr; b_l = burst_len; b_d = burst_dir;
    end
  end

  // expected fetch and burst lists, derived from the requirements
  task automatic compute_expected(input logic [AW-1:0] base, input longint cnt);
    longint      rem, seg_len, l, b;
    logic [31:0] seg_addr, sz;
    logic        seg_last;
    int          p;
    rem = cnt; seg_len = 0; seg_last = 0; seg_addr = '0; p = 0;
    nef = 0; neb = 0; exp_status = 2'b01;
    while (rem > 0) begin
      if (seg_len == 0) begin
        if (seg_last || p * 8 >= FS) begin exp_status = 2'b10; break; end
        exp_f[nef] = base + AW'(p * 8); nef++;
        sz = tbl[p][63:32]; seg_addr = tbl[p][31:0];
        l = longint'(sz & 32'h0000_FFFE);
        if (l == 0) l = 65536;
        seg_len = l; seg_last = sz[31]; p++;
      end
      b = (rem < seg_len) ? rem : seg_len;
      exp_ba[neb] = seg_addr; exp_bl[neb] = b; neb++;
      seg_addr = seg_addr + 32'(b); seg_len -= b; rem -= b;
    end
  endtask

  task automatic run_case(input logic [AW-1:0] base, input longint cnt,
                          input logic dir, input bit poke, input string tag);
    int old, guard;
    compute_expected(base, cnt);
    mem_base = base; nf = 0; nb = 0; old = ndone;
    @(negedge clk);
    start = 1; table_base = base; byte_count = CNT_W'(cnt); dir_to_mem = dir;
    @(negedge clk);
    start = 0;
    if (poke) begin
      // R10: a second start while running must change nothing
      repeat (2) @(negedge clk);
      chk(busy == 1'b1, "R10", {tag, " busy at poke"}, busy, 1);
      start = 1; table_base = base + 32'h100; byte_count = 1; dir_to_mem = !dir;
      @(negedge clk);
      start = 0;
    end
    guard = 0;
    while (ndone == old && guard < 5000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    chk(ndone == old + 1, "R8", {tag, " done pulses"}, ndone - old, 1);
    chk(done_status == exp_status, "R8", {tag, " status"}, done_status, exp_status);
    chk(err == (exp_status == 2'b10), "R8", {tag, " err"}, err, exp_status == 2'b10);
    chk(!busy, "R8", {tag, " busy low"}, busy, 0);
    // R4/R7: fetch list starts at base and steps by 8
    chk(nf == nef, "R4", {tag, " fetch count"}, nf, nef);
    for (int i = 0; i < nf && i < nef && i < 32; i++)
      chk(got_f[i] == exp_f[i], "R4", {tag, " fetch addr"}, got_f[i], exp_f[i]);
    chk(nb == neb, "R6", {tag, " burst count"}, nb, neb);
    for (int i = 0; i < nb && i < neb && i < 32; i++) begin
      chk(got_ba[i] == exp_ba[i], "R6", {tag, " burst addr"}, got_ba[i], exp_ba[i]);
      chk(longint'(got_bl[i]) == exp_bl[i], "R6", {tag, " burst len"}, got_bl[i], exp_bl[i]);
      chk(got_bd[i] == dir, "R12", {tag, " burst dir"}, got_bd[i], dir);
    end
  endtask

  task automatic load_a();
    for (int i = 0; i < 16; i++) tbl[i] = '0;
    tbl[0] = {32'h0000_0100, 32'h2000_0000};
    tbl[1] = {32'h0000_0031, 32'h2000_1000};   // R1: odd size, bit 0 dropped -> 0x30
    tbl[2] = {32'h8000_0040, 32'h2000_2000};   // R3: end marker
  endtask

  task automatic load_b();
    for (int i = 0; i < 16; i++) tbl[i] = '0;
    tbl[0] = {32'h7FFF_0000, 32'h3000_0000};   // R2: zero length = 64 KiB, R1: bits 62:48 ignored
    tbl[1] = {32'h8000_0101, 32'h3001_0000};
  endtask

  task automatic load_c();
    for (int i = 0; i < 16; i++) tbl[i] = {32'h0000_0003, 32'h4000_0000 + 32'(i * 16)};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    lat = 0; mem_base = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && done_status == 2'b00 && !err, "R8", "reset state",
        {busy, done, done_status, err}, 0);
    chk(!fetch_valid && !burst_valid && !resp_ready, "R10", "reset handshakes",
        {fetch_valid, burst_valid, resp_ready}, 0);

    // sweep over byte counts; count 0 covers R11, repeated runs from the
    // same base after partial use cover R7, counts past 0x170 cover R3
    load_a();
    for (int c = 0; c <= 400; c += 5) begin
      lat = (c / 5) % 3;
      run_case(32'h0001_0000, c, ((c / 5) % 2) == 1, 0, $sformatf("R11/R7/R3 tblA cnt=%0d", c));
    end

    load_b();
    lat = 1;
    run_case(32'h0002_0000, 65536, 1, 0, "R2 exact 64K");
    run_case(32'h0002_0000, 65600, 0, 0, "R2 64K plus");
    run_case(32'h0002_0000, 70000, 1, 0, "R1 R3 exhausted");

    load_c();
    lat = 2;
    run_case(32'h0003_0000, 10, 0, 0, "R5 short run");
    run_case(32'h0003_0000, 100, 1, 0, "R5 failsafe stop");

    load_a();
    lat = 2;
    run_case(32'h0001_0000, 300, 1, 1, "R10 start while busy");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule